// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Readout Controller

This block is a serial-bus master that reads a chain of identical eight-input serializer chips wired in a daisy chain. Each start pulse runs one frame. Chip select goes low and stays low for the whole frame. The clock idles low, and the block samples the data line on each rising clock edge. It shifts in eight bits per chip in the short format, or sixteen bits per chip when the status format is selected.

When the frame ends, the block takes each chip's input byte out of the stream. In the status format it also takes the status byte that follows it. It checks a five-bit CRC, decodes the temperature bit and the two active-low supply bits, and merges the result with an external fault line for each chip. A strap can mask the supply bits and the fault lines for boards that power the chips from a low supply rail. All result vectors are updated in the same cycle, and one-cycle `frameDone` pulse marks that cycle. A faulting chip does not spoil the data or the flags of the other chips, so software can still use the chips that are healthy.

A parameter selects the fault-line wiring. There can be one line per chip, or one line shared by every chip in the chain.

Top module: `serialChainReader`

## Requirements
- R1: After reset, `spiCsN` is 1, `spiSclk` is 0, `frameDone` is 0, and every result vector is all zeros.
- R2: A start pulse accepted while idle begins a frame. `spiCsN` stays 0 for the whole frame. `spiSclk` is 0 whenever `spiCsN` is 1, and each clock level lasts HALF_DIV cycles. The frame has 8·NUM_CHIPS rising edges when `statusMode`=0 and 16·NUM_CHIPS rising edges when `statusMode`=1. `statusMode` is latched at the start.
- R3: The block samples the data line on each rising edge, most significant bit first. Stream byte k is the k-th group of eight bits received. Chip i's input byte is stream byte i·W, where W=1 in the short format and W=2 in the status format, and it appears on `inputBits[8i+7:8i]`. In the status format, chip i's status byte is stream byte 2i+1.
- R4: In the status format, `crcErr[i]` is 1 when status bits [7:3] differ from the CRC of the input byte. The CRC uses polynomial x^5+x^4+x^2+1 and initial value 0, processes the byte most significant bit first, and its result lies in bits [7:3].
- R5: In the status format, `overTemp[i]` is status bit 1. `uvAlarm[i]` is status bit 2 inverted, and `uvWarn[i]` is status bit 0 inverted. In the short format, `crcErr`, `overTemp`, `uvAlarm` and `uvWarn` are all 0.
- R6: When `ignoreUv`=1, `uvAlarm`, `uvWarn` and `faultSeen` are 0, and the supply bits and fault lines have no effect on `chipFault`.
- R7: `chipFault[i]` is the OR of `faultSeen[i]`, `crcErr[i]`, `overTemp[i]` and `uvAlarm[i]`. A supply warning on its own does not set it.
- R8: `faultSeen[i]` takes the value of the fault line in the last frame cycle. With FAULT_SHARED=0, chip i uses `faultPin[i]`. With FAULT_SHARED=1, every chip uses `faultPin[0]`.
- R9: Each chip's data and flags depend only on that chip's bytes and that chip's fault line.
- R10: `frameDone` is a one-cycle pulse in the cycle after `spiCsN` returns to 1. All result vectors change only at that edge and hold until the next completed frame.
- R11: A start pulse that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request one frame (taken only when idle) |
| statusMode | input | 1 | 1 selects the two-byte status format, 0 the one-byte format |
| ignoreUv | input | 1 | Mask the supply bits and the fault lines |
| faultPin | input | FAULT_W | Fault lines: NUM_CHIPS lines, or 1 when shared |
| spiSclk | output | 1 | Serial clock, idles low |
| spiCsN | output | 1 | Chip select, active low |
| spiMiso | input | 1 | Serial data from the end of the chain |
| inputBits | output | 8·NUM_CHIPS | Input states, chip i in bits [8i+7:8i] |
| crcErr | output | NUM_CHIPS | CRC mismatch, one bit per chip |
| overTemp | output | NUM_CHIPS | Overtemperature, one bit per chip |
| uvAlarm | output | NUM_CHIPS | Supply alarm, one bit per chip |
| uvWarn | output | NUM_CHIPS | Supply warning, one bit per chip |
| faultSeen | output | NUM_CHIPS | Fault line sampled, one bit per chip |
| chipFault | output | NUM_CHIPS | Chip data must not be trusted |
| frameDone | output | 1 | One-cycle pulse when the results update |

## Verification
A wrong bit counter or a wrong latched format shows directly on `spiCsN`, `spiSclk` and the timing of `frameDone`. The bench compares these three every cycle, so the fault is caught at the first edge that comes early or late. A byte-selection or decode error cannot be seen until the frame completes. It then appears as a mismatch on one chip's slice of the result vectors in the `frameDone` cycle, and the bench's test frames give each chip a different fault so that a wrong slice is easy to identify. A result register that updates outside `frameDone` is caught while the outputs should be holding, because the bench changes the straps and the fault lines between frames.

// File: rtl/serChainPkg.sv
package serChainPkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic frameStart;
    logic sampleEn;
    logic frameEnd;
    logic wideMode;
  } chainStrobes_t;

  // Five-bit check code in bits [7:3]; polynomial x^5+x^4+x^2+1, seed 0, MSB first.
  function automatic logic [7:0] calcCrc5(input logic [7:0] dataByte);
    logic [7:0] acc;
    acc = dataByte;
    for (int k = 0; k < 8; k++) begin
      acc = acc[7] ? ({acc[6:0], 1'b0} ^ 8'hA8) : {acc[6:0], 1'b0};
    end
    return acc & 8'hF8;
  endfunction

endpackage

// File: rtl/serChainCtrl.sv
module serChainCtrl
  import serChainPkg::*;
#(
  parameter int NUM_CHIPS = 3,
  parameter int HALF_DIV  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          statusMode,
  output logic          spiSclk,
  output logic          spiCsN,
  output chainStrobes_t strb
);

  localparam int MAX_BITS = 2 * BYTE_W * NUM_CHIPS;
  localparam int BIT_W    = $clog2(MAX_BITS);
  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(MAX_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(BYTE_W * NUM_CHIPS - 1);
  localparam logic [DIV_W-1:0] DIV_LAST    = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} ctrlState_t;

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkReg;
  logic             csReg;
  logic             wideReg;
  logic             halfTick;
  logic [BIT_W-1:0] lastBit;

  assign halfTick = (divCnt == DIV_LAST);
  assign lastBit  = wideReg ? LAST_WIDE : LAST_NARROW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclkReg <= 1'b0;
      csReg   <= 1'b1;
      wideReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            state   <= ST_RUN;
            csReg   <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            sclkReg <= 1'b0;
            wideReg <= statusMode;
          end
        end
        ST_RUN: begin
          if (halfTick) begin
            divCnt  <= '0;
            sclkReg <= !sclkReg;
            if (sclkReg) begin
              if (bitCnt == lastBit) begin
                state <= ST_FINISH;
                csReg <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.frameStart = (state == ST_IDLE) && startPulse;
    strb.sampleEn   = (state == ST_RUN) && halfTick && !sclkReg;
    strb.frameEnd   = (state == ST_FINISH);
    strb.wideMode   = wideReg;
  end

  assign spiSclk = sclkReg;
  assign spiCsN  = csReg;

endmodule

// File: rtl/serChainChipCheck.sv
module serChainChipCheck
  import serChainPkg::*;
(
  input  logic [7:0] inByte,
  input  logic [7:0] statusByte,
  input  logic       wideMode,
  input  logic       ignoreUv,
  input  logic       faultLine,
  output logic       crcBad,
  output logic       hot,
  output logic       uvAlm,
  output logic       uvWrn,
  output logic       pinFault,
  output logic       faulty
);

  logic [7:0] expCode;

  always_comb begin
    expCode  = calcCrc5(inByte);
    crcBad   = wideMode && ((statusByte & 8'hF8) != expCode);
    hot      = wideMode && statusByte[1];
    uvAlm    = wideMode && !ignoreUv && !statusByte[2];
    uvWrn    = wideMode && !ignoreUv && !statusByte[0];
    pinFault = !ignoreUv && faultLine;
    faulty   = pinFault || crcBad || hot || uvAlm;
  end

endmodule

// File: rtl/serChainData.sv
module serChainData
  import serChainPkg::*;
#(
  parameter int NUM_CHIPS    = 3,
  parameter bit FAULT_SHARED = 1'b0,
  localparam int FAULT_W     = FAULT_SHARED ? 1 : NUM_CHIPS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  chainStrobes_t               strb,
  input  logic                        spiMiso,
  input  logic                        ignoreUv,
  input  logic [FAULT_W-1:0]          faultPin,
  output logic [BYTE_W*NUM_CHIPS-1:0] inputBits,
  output logic [NUM_CHIPS-1:0]        crcErr,
  output logic [NUM_CHIPS-1:0]        overTemp,
  output logic [NUM_CHIPS-1:0]        uvAlarm,
  output logic [NUM_CHIPS-1:0]        uvWarn,
  output logic [NUM_CHIPS-1:0]        faultSeen,
  output logic [NUM_CHIPS-1:0]        chipFault,
  output logic                        frameDone
);

  localparam int MAX_BITS    = 2 * BYTE_W * NUM_CHIPS;
  localparam int WIDE_BYTES  = 2 * NUM_CHIPS;

  logic [MAX_BITS-1:0]         shiftReg;
  logic [BYTE_W*NUM_CHIPS-1:0] nextIn;
  logic [NUM_CHIPS-1:0]        nextCrc, nextHot, nextUvA, nextUvW, nextPin, nextFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.sampleEn) begin
      shiftReg <= {shiftReg[MAX_BITS-2:0], spiMiso};
    end
  end

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
    logic [7:0] wideIn, wideSt, narrowIn, selIn;
    logic       line;

    // Earlier bytes sit higher in the shift register.
    assign wideIn   = shiftReg[(WIDE_BYTES - 1 - 2*i)*BYTE_W +: BYTE_W];
    assign wideSt   = shiftReg[(WIDE_BYTES - 2 - 2*i)*BYTE_W +: BYTE_W];
    assign narrowIn = shiftReg[(NUM_CHIPS - 1 - i)*BYTE_W +: BYTE_W];
    assign selIn    = strb.wideMode ? wideIn : narrowIn;

    if (FAULT_SHARED) begin : g_shared
      assign line = faultPin[0];
    end else begin : g_own
      assign line = faultPin[i];
    end

    serChainChipCheck chk_u (
      .inByte     (selIn),
      .statusByte (wideSt),
      .wideMode   (strb.wideMode),
      .ignoreUv   (ignoreUv),
      .faultLine  (line),
      .crcBad     (nextCrc[i]),
      .hot        (nextHot[i]),
      .uvAlm      (nextUvA[i]),
      .uvWrn      (nextUvW[i]),
      .pinFault   (nextPin[i]),
      .faulty     (nextFault[i])
    );

    assign nextIn[i*BYTE_W +: BYTE_W] = selIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputBits <= '0;
      crcErr    <= '0;
      overTemp  <= '0;
      uvAlarm   <= '0;
      uvWarn    <= '0;
      faultSeen <= '0;
      chipFault <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.frameEnd;
      if (strb.frameEnd) begin
        inputBits <= nextIn;
        crcErr    <= nextCrc;
        overTemp  <= nextHot;
        uvAlarm   <= nextUvA;
        uvWarn    <= nextUvW;
        faultSeen <= nextPin;
        chipFault <= nextFault;
      end
    end
  end

endmodule

// File: rtl/serialChainReader.sv
module serialChainReader
  import serChainPkg::*;
#(
  parameter int NUM_CHIPS    = 3,
  parameter int HALF_DIV     = 2,
  parameter bit FAULT_SHARED = 1'b0,
  localparam int FAULT_W     = FAULT_SHARED ? 1 : NUM_CHIPS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startPulse,
  input  logic                   statusMode,
  input  logic                   ignoreUv,
  input  logic [FAULT_W-1:0]     faultPin,
  output logic                   spiSclk,
  output logic                   spiCsN,
  input  logic                   spiMiso,
  output logic [8*NUM_CHIPS-1:0] inputBits,
  output logic [NUM_CHIPS-1:0]   crcErr,
  output logic [NUM_CHIPS-1:0]   overTemp,
  output logic [NUM_CHIPS-1:0]   uvAlarm,
  output logic [NUM_CHIPS-1:0]   uvWarn,
  output logic [NUM_CHIPS-1:0]   faultSeen,
  output logic [NUM_CHIPS-1:0]   chipFault,
  output logic                   frameDone
);

  chainStrobes_t strb;

  serChainCtrl #(.NUM_CHIPS(NUM_CHIPS), .HALF_DIV(HALF_DIV)) ctrl_u (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .statusMode (statusMode),
    .spiSclk    (spiSclk),
    .spiCsN     (spiCsN),
    .strb       (strb)
  );

  serChainData #(.NUM_CHIPS(NUM_CHIPS), .FAULT_SHARED(FAULT_SHARED)) data_u (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .spiMiso   (spiMiso),
    .ignoreUv  (ignoreUv),
    .faultPin  (faultPin),
    .inputBits (inputBits),
    .crcErr    (crcErr),
    .overTemp  (overTemp),
    .uvAlarm   (uvAlarm),
    .uvWarn    (uvWarn),
    .faultSeen (faultSeen),
    .chipFault (chipFault),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/serialChainReader_chk.sv
module serialChainReader_chk #(
  parameter int NUM_CHIPS = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   spiCsN,
  input logic                   spiSclk,
  input logic                   ignoreUv,
  input logic                   frameEnd,
  input logic                   wideMode,
  input logic                   frameDone,
  input logic [8*NUM_CHIPS-1:0] inputBits,
  input logic [NUM_CHIPS-1:0]   crcErr,
  input logic [NUM_CHIPS-1:0]   overTemp,
  input logic [NUM_CHIPS-1:0]   uvAlarm,
  input logic [NUM_CHIPS-1:0]   uvWarn,
  input logic [NUM_CHIPS-1:0]   faultSeen,
  input logic [NUM_CHIPS-1:0]   chipFault
);

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  p_done_after_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(frameEnd) && spiCsN));

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> ($stable(inputBits) && $stable(crcErr) && $stable(overTemp) &&
                    $stable(uvAlarm) && $stable(uvWarn) && $stable(faultSeen) &&
                    $stable(chipFault)));

  p_ignore_masks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && $past(ignoreUv)) |-> (uvAlarm == '0 && uvWarn == '0 && faultSeen == '0));

  p_short_no_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !$past(wideMode)) |-> (crcErr == '0 && overTemp == '0 &&
                                          uvAlarm == '0 && uvWarn == '0));

endmodule

bind serialChainReader serialChainReader_chk #(.NUM_CHIPS(NUM_CHIPS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .spiCsN    (spiCsN),
  .spiSclk   (spiSclk),
  .ignoreUv  (ignoreUv),
  .frameEnd  (strb.frameEnd),
  .wideMode  (strb.wideMode),
  .frameDone (frameDone),
  .inputBits (inputBits),
  .crcErr    (crcErr),
  .overTemp  (overTemp),
  .uvAlarm   (uvAlarm),
  .uvWarn    (uvWarn),
  .faultSeen (faultSeen),
  .chipFault (chipFault)
);

// File: tb/serialChainReader_tb_top.sv
module serialChainReader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 3;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic statusMode = 1'b0;
  logic ignoreUv = 1'b0;
  logic [N-1:0] faultPin = '0;
  logic spiSclk, spiCsN, spiMiso, frameDone;
  logic [8*N-1:0] inputBits;
  logic [N-1:0] crcErr, overTemp, uvAlarm, uvWarn, faultSeen, chipFault;

  logic shSclk, shCsN, shDone;
  logic [8*N-1:0] shIn;
  logic [N-1:0] shCrc, shHot, shUvA, shUvW, shSeen, shFault;

  int errCount = 0;
  int checkCount = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  serialChainReader #(.NUM_CHIPS(N), .HALF_DIV(HALF), .FAULT_SHARED(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .statusMode(statusMode),
    .ignoreUv(ignoreUv), .faultPin(faultPin), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMiso(spiMiso), .inputBits(inputBits), .crcErr(crcErr), .overTemp(overTemp),
    .uvAlarm(uvAlarm), .uvWarn(uvWarn), .faultSeen(faultSeen), .chipFault(chipFault),
    .frameDone(frameDone));

  serialChainReader #(.NUM_CHIPS(N), .HALF_DIV(HALF), .FAULT_SHARED(1'b1)) dutShared_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .statusMode(statusMode),
    .ignoreUv(ignoreUv), .faultPin(faultPin[0:0]), .spiSclk(shSclk), .spiCsN(shCsN),
    .spiMiso(spiMiso), .inputBits(shIn), .crcErr(shCrc), .overTemp(shHot),
    .uvAlarm(shUvA), .uvWarn(shUvW), .faultSeen(shSeen), .chipFault(shFault),
    .frameDone(shDone));

  // Serializer chain model: first bit ready when select falls, next bit on each falling clock.
  logic [7:0] tx [0:2*N-1];
  int txLen = 0;
  int ptr = 0;
  int riseCnt = 0;

  always @(negedge spiCsN) begin ptr = 0; riseCnt = 0; end
  always @(negedge spiSclk) if (!spiCsN) ptr++;
  always @(posedge spiSclk) riseCnt++;
  assign spiMiso = (ptr < txLen*8) ? tx[ptr/8][7 - (ptr%8)] : 1'b0;

  // Polynomial division of d*x^5 by x^5+x^4+x^2+1.
  function automatic logic [7:0] refCrc(input logic [7:0] d);
    int rem;
    rem = int'(d) << 5;
    for (int b = 12; b >= 5; b--) if (rem[b]) rem = rem ^ (32'h35 << (b - 5));
    return {rem[4:0], 3'b000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising clock.
  bit mBusy = 0;
  bit mWide = 0;
  int mCnt = 0;
  int mBits = 0;
  logic eCs = 1'b1, eSclk = 1'b0, eDone = 1'b0;
  logic [8*N-1:0] eIn = '0;
  logic [N-1:0] eCrc = '0, eHot = '0, eUvA = '0, eUvW = '0, eSeen = '0, eFault = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; eCs = 1'b1; eSclk = 1'b0; eDone = 1'b0;
      eIn = '0; eCrc = '0; eHot = '0; eUvA = '0; eUvW = '0; eSeen = '0; eFault = '0;
    end else begin
      eDone = 1'b0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == 2*mBits*HALF) eCs = 1'b1;
        if (mCnt == 2*mBits*HALF + 1) begin
          for (int i = 0; i < N; i++) begin
            logic [7:0] inB, st;
            inB = mWide ? tx[2*i] : tx[i];
            st  = tx[2*i+1];
            eIn[8*i +: 8] = inB;
            eCrc[i]  = mWide && ({st[7:3], 3'b000} != refCrc(inB));
            eHot[i]  = mWide && st[1];
            eUvA[i]  = mWide && !st[2] && !ignoreUv;
            eUvW[i]  = mWide && !st[0] && !ignoreUv;
            eSeen[i] = !ignoreUv && faultPin[i];
            eFault[i] = eSeen[i] | eCrc[i] | eHot[i] | eUvA[i];
          end
          eDone = 1'b1;
          mBusy = 0;
        end
      end else if (startPulse) begin
        mBusy = 1; mCnt = 0; mWide = statusMode;
        mBits = statusMode ? 16*N : 8*N;
        eCs = 1'b0;
      end
      eSclk = mBusy && (mCnt < 2*mBits*HALF) && (((mCnt / HALF) % 2) == 1);
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN) begin
      check(spiCsN == eCs && spiSclk == eSclk, "R2 select/clock timing",
            {spiCsN, spiSclk}, {eCs, eSclk});
      check(frameDone == eDone, "R10 done pulse timing", frameDone, eDone);
      check({inputBits, chipFault} == {eIn, eFault}, "R3 data/fault vector",
            {inputBits, chipFault}, {eIn, eFault});
      check({crcErr, overTemp, uvAlarm, uvWarn, faultSeen} == {eCrc, eHot, eUvA, eUvW, eSeen},
            "R5 status flag vectors", {crcErr, overTemp, uvAlarm, uvWarn, faultSeen},
            {eCrc, eHot, eUvA, eUvW, eSeen});
    end
  end

  task automatic loadGood(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    tx[0] = b0; tx[1] = refCrc(b0) | 8'h05;
    tx[2] = b1; tx[3] = refCrc(b1) | 8'h05;
    tx[4] = b2; tx[5] = refCrc(b2) | 8'h05;
  endtask

  task automatic runFrame(input bit wide, input bit extraStart);
    @(negedge clk);
    statusMode = wide;
    txLen = wide ? 2*N : N;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (extraStart) begin
      repeat (30) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (!frameDone) @(negedge clk);
    check(riseCnt == (wide ? 16*N : 8*N), "R2 rising edges per frame", riseCnt, wide ? 16*N : 8*N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2*N; k++) tx[k] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(spiCsN == 1'b1 && spiSclk == 1'b0 && frameDone == 1'b0, "R1 idle pins",
          {spiCsN, spiSclk, frameDone}, 3'b100);
    check({inputBits, crcErr, overTemp, uvAlarm, uvWarn, faultSeen, chipFault} == '0,
          "R1 result vectors zero", {inputBits, chipFault}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Frame 1: clean status frame
    loadGood(8'hA5, 8'h3C, 8'hFF);
    runFrame(1'b1, 1'b0);
    check(inputBits == 24'hFF3CA5, "R3 chip byte placement", inputBits, 24'hFF3CA5);
    check(crcErr == 3'b000 && chipFault == 3'b000, "R4 good codes accepted", {crcErr, chipFault}, 0);

    // Frame 2: one fault kind per chip
    loadGood(8'h5A, 8'hC3, 8'h0F);
    tx[1] = tx[1] ^ 8'h08;
    tx[3] = tx[3] | 8'h02;
    tx[5] = tx[5] & 8'hFE;
    runFrame(1'b1, 1'b0);
    check(crcErr == 3'b001, "R4 code mismatch chip0", crcErr, 3'b001);
    check(overTemp == 3'b010, "R5 overtemperature chip1", overTemp, 3'b010);
    check(uvWarn == 3'b100 && uvAlarm == 3'b000, "R5 warning chip2", {uvWarn, uvAlarm}, 6'b100000);
    check(chipFault == 3'b011, "R7 warning alone not faulting", chipFault, 3'b011);
    check(inputBits == 24'h0FC35A, "R9 data kept despite faults", inputBits, 24'h0FC35A);

    // Frame 3: supply alarm chip0, fault line chip2
    loadGood(8'h12, 8'h34, 8'h56);
    tx[1] = tx[1] & 8'hFB;
    faultPin = 3'b100;
    runFrame(1'b1, 1'b0);
    check(uvAlarm == 3'b001 && faultSeen == 3'b100, "R8 per-chip fault line",
          {uvAlarm, faultSeen}, 6'b001100);
    check(chipFault == 3'b101, "R7 fault merge", chipFault, 3'b101);
    check(shSeen == 3'b000 && shFault == 3'b001, "R8 shared line low", {shSeen, shFault}, 6'b000001);

    // R10: straps change after completion, results hold
    faultPin = 3'b011;
    ignoreUv = 1'b1;
    repeat (10) @(negedge clk);
    check(chipFault == 3'b101 && faultSeen == 3'b100, "R10 results hold", {chipFault, faultSeen}, 6'b101100);

    // Frame 4: same data, supply checks masked
    faultPin = 3'b100;
    runFrame(1'b1, 1'b0);
    check({uvAlarm, uvWarn, faultSeen} == '0, "R6 masked supply and lines",
          {uvAlarm, uvWarn, faultSeen}, 0);
    check(chipFault == 3'b000, "R6 mask clears faults", chipFault, 0);
    ignoreUv = 1'b0;

    // Frame 5: short format, fault line chip0
    tx[0] = 8'h81; tx[1] = 8'h7E; tx[2] = 8'h00;
    faultPin = 3'b001;
    runFrame(1'b0, 1'b0);
    check(inputBits == 24'h007E81, "R3 short format placement", inputBits, 24'h007E81);
    check({crcErr, overTemp, uvAlarm, uvWarn} == '0, "R5 short format no status",
          {crcErr, overTemp, uvAlarm, uvWarn}, 0);
    check(chipFault == 3'b001, "R8 short format fault line", chipFault, 3'b001);
    check(shFault == 3'b111, "R8 shared line hits all chips", shFault, 3'b111);
    faultPin = 3'b000;

    // Frame 6: extra start mid-frame is ignored
    loadGood(8'h01, 8'h80, 8'h44);
    runFrame(1'b1, 1'b1);
    check(inputBits == 24'h448001, "R11 frame data intact", inputBits, 24'h448001);
    begin
      bit stayedIdle;
      stayedIdle = 1;
      repeat (20) begin
        @(negedge clk);
        if (!spiCsN) stayedIdle = 0;
      end
      check(stayedIdle, "R11 no second frame", {63'b0, stayedIdle}, 1);
    end

    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end

endmodule